// File: doc/BRIEF.md
# Triggered hit buffer and packet builder

This block sits in the readout FPGA between the front-end chip receivers and the event collection link. It counts beam crossings on an 8-bit counter, forwards each beam tick towards the chips, and stores every incoming 24-bit hit word in a circular buffer. A stored word stays usable for a window of recent beam clocks. The input stream is already zero suppressed, so every valid input cycle carries one real hit.

When a level-1 accept arrives, the block works out which crossing the trigger refers to. That crossing is the present counter value minus a programmable latency, taken modulo 256. Every live buffered word that carries this tag goes into a packet. The packet opens with a header word and closes with a trailer word, and it leaves over a valid/ready stream. Reading does not remove data, so the same crossing can be requested again.

Top module: `trig_hit_packer`

## Requirements
- R1: While reset is held, and right after it, `outValid` is 0, `bcoCount` is 0, `chipTick` is 0 and both trailer flags are clear.
- R2: Each cycle with `bcoTick` high adds one to `bcoCount`, wrapping modulo 256. `chipTick` is high in the cycle that follows each tick, at the same time as the new count.
- R3: A hit word has the layout channel [23:15], ADC [14:12], chip [11:8], beam tag [7:0]. Every hit word in a packet appears bit for bit as it was received.
- R4: On `l1Accept` the block forms the trigger tag as `bcoCount - l1Latency` mod 256. The packet holds every live buffered word with that tag, oldest first.
- R5: The first word of a packet is the header: [23:20]=4'hA, [19:16]=0, [15:8]=number of hit words, [7:0]=trigger tag.
- R6: The last word of a packet is the trailer: [23:20]=4'hC, [19:10]=0, [9]=late flag, [8]=overwrite flag, [7:0]=trigger tag. `outLast` is high on the trailer only.
- R7: A trigger whose tag matches no live word still yields a header with a count of 0, followed directly by the trailer.
- R8: A hit whose age (`bcoCount` minus its tag, mod 256) is 64 or more is not stored. It sets the late flag of the next packet, and the flag is clear again in the packet after that.
- R9: A stored word is live while its age is below 64. At age 64 it is never sent again.
- R10: The buffer holds 64 words. A new word written into a slot that still holds a live word replaces it and sets the overwrite flag of the next packet.
- R11: A level-1 accept that arrives while a packet is being sent is ignored; no second packet follows.
- R12: While `outValid` is high and `outReady` is low, the word is held. Sending a packet leaves the buffer unchanged, so requesting the same tag again gives the same packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bcoTick | input | 1 | One beam crossing has elapsed |
| hitValid | input | 1 | `hitWord` carries a hit this cycle |
| hitWord | input | 24 | Hit word from the chip receivers |
| l1Accept | input | 1 | Level-1 accept pulse |
| l1Latency | input | 8 | Trigger latency in beam clocks |
| outReady | input | 1 | Downstream can take a word |
| outValid | output | 1 | `outData` holds a packet word |
| outData | output | 24 | Packet word |
| outLast | output | 1 | Current word is the trailer |
| bcoCount | output | 8 | Beam clock counter |
| chipTick | output | 1 | Beam tick forwarded to the chips |

## Verification
The buffer is preloaded with eight hits spread over four tags. It is then triggered at several latencies, with the output both free-running and stalled on every other cycle. These runs separate tags with many matches, a single match and no match, and they show that a stalled output loses and repeats no word. Hits that arrive late or from the future, a trigger exactly at the 63/64 age boundary, and a wrap of the buffer onto live words check the drop, expiry and overwrite rules. The wrap case also checks oldest-first order across the slot index wrap. A second accept during a stalled packet checks that triggers are refused while a packet is being sent.

// File: rtl/thp_pkg.sv
package thp_pkg;
  localparam int WORD_W = 24;
  localparam int TAG_W  = 8;

  localparam logic [3:0] HDR_MARK = 4'hA;
  localparam logic [3:0] TRL_MARK = 4'hC;

  typedef enum logic [1:0] {
    SEL_HDR = 2'd0,
    SEL_HIT = 2'd1,
    SEL_TRL = 2'd2
  } outSel_e;

  // strobes from the packet control to the datapath
  typedef struct packed {
    logic    snap;    // latch trigger tag, match set, count and flags
    logic    popHit;  // the current hit word has been taken
    outSel_e sel;     // which word drives outData
  } ctrlStrobes_t;

  // status from the datapath back to the control
  typedef struct packed {
    logic hasHits;    // match set not empty
    logic moreAfter;  // hits remain beyond the current one
  } dpStatus_t;
endpackage

// File: rtl/thp_datapath.sv
module thp_datapath
  import thp_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WINDOW = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bcoTick,
  input  logic                hitValid,
  input  logic [WORD_W-1:0]   hitWord,
  input  logic [TAG_W-1:0]    l1Latency,
  input  ctrlStrobes_t        strobes,
  output dpStatus_t           status,
  output logic [TAG_W-1:0]    bcoCount,
  output logic                chipTick,
  output logic [WORD_W-1:0]   outData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [TAG_W-1:0]  bcoCountQ;
  logic              chipTickQ;
  logic [WORD_W-1:0] slotWord [DEPTH];
  logic [DEPTH-1:0]  slotValid;
  logic [DEPTH-1:0]  liveVec;
  logic [DEPTH-1:0]  matchVec;
  logic [PTR_W-1:0]  wrPtr;
  logic [TAG_W-1:0]  trigTag;
  logic [TAG_W-1:0]  hitAge;
  logic              hitFresh;
  logic              lateEvt;
  logic              overEvt;
  logic              lateFlag;
  logic              overFlag;
  logic              pktLate;
  logic              pktOver;
  logic [DEPTH-1:0]  maskQ;
  logic [PTR_W-1:0]  baseQ;
  logic [PTR_W-1:0]  curSlot;
  logic [7:0]        hitCountQ;
  logic [TAG_W-1:0]  pktTag;

  // beam clock counter and the tick forwarded to the chips
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcoCountQ <= '0;
      chipTickQ <= 1'b0;
    end else begin
      chipTickQ <= bcoTick;
      if (bcoTick) bcoCountQ <= bcoCountQ + 1'b1;
    end
  end

  assign bcoCount = bcoCountQ;
  assign chipTick = chipTickQ;
  assign trigTag  = bcoCountQ - l1Latency;

  // age test of the incoming word
  assign hitAge   = bcoCountQ - hitWord[TAG_W-1:0];
  assign hitFresh = hitValid && (int'(hitAge) < WINDOW);
  assign lateEvt  = hitValid && !hitFresh;

  // per-slot liveness and tag match
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic [TAG_W-1:0] slotAge;
    assign slotAge      = bcoCountQ - slotWord[gi][TAG_W-1:0];
    assign liveVec[gi]  = slotValid[gi] && (int'(slotAge) < WINDOW);
    assign matchVec[gi] = liveVec[gi] && (slotWord[gi][TAG_W-1:0] == trigTag);
  end

  assign overEvt = hitFresh && liveVec[wrPtr];

  always_ff @(posedge clk) begin
    if (hitFresh) slotWord[wrPtr] <= hitWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      wrPtr     <= '0;
    end else begin
      slotValid <= liveVec;
      if (hitFresh) begin
        slotValid[wrPtr] <= 1'b1;
        wrPtr            <= wrPtr + 1'b1;
      end
    end
  end

  // sticky flags; handed to the packet at trigger time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lateFlag <= 1'b0;
      overFlag <= 1'b0;
      pktLate  <= 1'b0;
      pktOver  <= 1'b0;
    end else begin
      lateFlag <= (strobes.snap ? 1'b0 : lateFlag) | lateEvt;
      overFlag <= (strobes.snap ? 1'b0 : overFlag) | overEvt;
      if (strobes.snap) begin
        pktLate <= lateFlag | lateEvt;
        pktOver <= overFlag | overEvt;
      end
    end
  end

  // match set snapshot, drained one hit per accepted word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= '0;
      baseQ     <= '0;
      hitCountQ <= '0;
      pktTag    <= '0;
    end else if (strobes.snap) begin
      maskQ     <= matchVec;
      baseQ     <= wrPtr;
      hitCountQ <= 8'($countones(matchVec));
      pktTag    <= trigTag;
    end else if (strobes.popHit) begin
      maskQ[curSlot] <= 1'b0;
    end
  end

  // oldest-first pick: lowest offset from the oldest slot wins
  always_comb begin
    curSlot = baseQ;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (maskQ[baseQ + PTR_W'(k)]) curSlot = baseQ + PTR_W'(k);
    end
  end

  assign status.hasHits   = |maskQ;
  assign status.moreAfter = |(maskQ & ~(DEPTH'(1) << curSlot));

  always_comb begin
    unique case (strobes.sel)
      SEL_HDR: outData = {HDR_MARK, 4'h0, hitCountQ, pktTag};
      SEL_HIT: outData = slotWord[curSlot];
      default: outData = {TRL_MARK, 10'd0, pktLate, pktOver, pktTag};
    endcase
  end

  // R2: forwarded tick comes with a counter step
  a_r2_fwd_tick: assert property (@(posedge clk) disable iff (!rstN)
    chipTick |-> (bcoCount == $past(bcoCount) + 8'd1));

  // R8: a stale hit raises the late flag
  a_r8_late_flag: assert property (@(posedge clk) disable iff (!rstN)
    hitValid && (int'(hitAge) >= WINDOW) |=> lateFlag);

  // R10: writing over a live slot raises the overwrite flag
  a_r10_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    hitValid && (int'(hitAge) < WINDOW) && liveVec[wrPtr] |=> overFlag);

  // R4, R7: no matched hit is left when the trailer goes out
  a_r4_drained: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.sel == SEL_TRL) |-> (maskQ == '0));
endmodule

// File: rtl/thp_control.sv
module thp_control
  import thp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         l1Accept,
  input  logic         outReady,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         outValid,
  output logic         outLast
);
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_BODY, ST_TRL} state_e;

  state_e state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (l1Accept) state <= ST_HDR;
        ST_HDR:  if (outReady) state <= status.hasHits ? ST_BODY : ST_TRL;
        ST_BODY: if (outReady && !status.moreAfter) state <= ST_TRL;
        default: if (outReady) state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.snap   = (state == ST_IDLE) && l1Accept;
    strobes.popHit = (state == ST_BODY) && outReady;
    unique case (state)
      ST_HDR:  strobes.sel = SEL_HDR;
      ST_BODY: strobes.sel = SEL_HIT;
      default: strobes.sel = SEL_TRL;
    endcase
  end

  assign outValid = (state != ST_IDLE);
  assign outLast  = (state == ST_TRL);

  // R11: an accept during a stalled packet does not disturb it
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) && l1Accept && !outReady |=> $stable(state));
endmodule

// File: rtl/trig_hit_packer.sv
module trig_hit_packer
  import thp_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WINDOW = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bcoTick,
  input  logic        hitValid,
  input  logic [23:0] hitWord,
  input  logic        l1Accept,
  input  logic [7:0]  l1Latency,
  input  logic        outReady,
  output logic        outValid,
  output logic [23:0] outData,
  output logic        outLast,
  output logic [7:0]  bcoCount,
  output logic        chipTick
);
  ctrlStrobes_t strobes;
  dpStatus_t    status;

  thp_datapath #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .bcoTick  (bcoTick),
    .hitValid (hitValid),
    .hitWord  (hitWord),
    .l1Latency(l1Latency),
    .strobes  (strobes),
    .status   (status),
    .bcoCount (bcoCount),
    .chipTick (chipTick),
    .outData  (outData)
  );

  thp_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .l1Accept(l1Accept),
    .outReady(outReady),
    .status  (status),
    .strobes (strobes),
    .outValid(outValid),
    .outLast (outLast)
  );

  // R12: a stalled word stays offered
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outLast));

  // R6: the last marker only comes with a valid word
  a_r6_last_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
endmodule

// File: tb/trig_hit_packer_bench.sv
module trig_hit_packer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bcoTick = 1'b0;
  logic        hitValid = 1'b0;
  logic [23:0] hitWord = '0;
  logic        l1Accept = 1'b0;
  logic [7:0]  l1Latency = '0;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [23:0] outData;
  logic        outLast;
  logic [7:0]  bcoCount;
  logic        chipTick;

  int checks = 0;
  int failures = 0;
  bit ended = 1'b0;

  // bench model of the buffer, built from the requirements
  logic [23:0] mWord [64];
  bit          mValid [64];
  int          mPtr = 0;
  logic [7:0]  mCnt = '0;
  bit          mLate = 1'b0;
  bit          mOver = 1'b0;

  always #4 clk = ~clk;

  trig_hit_packer u_trig_hit_packer (
    .clk(clk), .rstN(rstN), .bcoTick(bcoTick), .hitValid(hitValid),
    .hitWord(hitWord), .l1Accept(l1Accept), .l1Latency(l1Latency),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .outLast(outLast), .bcoCount(bcoCount), .chipTick(chipTick)
  );

  // preloaded hits: {channel, adc, chip, tag}
  localparam logic [23:0] HIT_TAB [8] = '{
    {9'd5,   3'd1, 4'd2,  8'd30},
    {9'd17,  3'd7, 4'd2,  8'd30},
    {9'd300, 3'd0, 4'd9,  8'd30},
    {9'd44,  3'd3, 4'd1,  8'd35},
    {9'd511, 3'd5, 4'd15, 8'd22},
    {9'd0,   3'd2, 4'd0,  8'd30},
    {9'd128, 3'd6, 4'd4,  8'd35},
    {9'd77,  3'd4, 4'd7,  8'd38}
  };

  // trigger rows at count 40: {latency, expected hit count, stall}
  localparam logic [23:0] TRIG_TAB [7] = '{
    {8'd10, 8'd4, 8'd0},
    {8'd5,  8'd2, 8'd1},
    {8'd18, 8'd1, 8'd0},
    {8'd2,  8'd1, 8'd1},
    {8'd7,  8'd0, 8'd0},
    {8'd0,  8'd0, 8'd1},
    {8'd10, 8'd4, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tickN(input int n);
    @(negedge clk);
    bcoTick = 1'b1;
    repeat (n) @(negedge clk);
    bcoTick = 1'b0;
    mCnt = mCnt + 8'(n);
  endtask

  task automatic sendHit(input logic [23:0] w);
    logic [7:0] ag;
    logic [7:0] oldAg;
    @(negedge clk);
    hitValid = 1'b1;
    hitWord  = w;
    @(negedge clk);
    hitValid = 1'b0;
    ag = mCnt - w[7:0];
    if (ag < 8'd64) begin
      oldAg = mCnt - mWord[mPtr][7:0];
      if (mValid[mPtr] && oldAg < 8'd64) mOver = 1'b1;
      mWord[mPtr]  = w;
      mValid[mPtr] = 1'b1;
      mPtr = (mPtr + 1) % 64;
    end else begin
      mLate = 1'b1;
    end
  endtask

  task automatic runTrigger(input logic [7:0] lat, input bit stall, input bit extra,
                            input string req, output int nHits);
    logic [23:0] expW [80];
    logic [23:0] got [80];
    logic [7:0]  tg;
    logic [7:0]  ag;
    int n;
    int gn;
    int guard;
    bit done;
    bit rdy;
    bit bodyOk;
    logic [23:0] badAct;
    logic [23:0] badExp;
    tg = mCnt - lat;
    ag = lat;
    n = 0;
    for (int k = 0; k < 64; k++) begin
      int s;
      s = (mPtr + k) % 64;
      if (mValid[s] && mWord[s][7:0] == tg && ag < 8'd64) begin
        expW[n] = mWord[s];
        n++;
      end
    end
    @(negedge clk);
    l1Latency = lat;
    l1Accept  = 1'b1;
    @(negedge clk);
    l1Accept = 1'b0;
    gn = 0;
    done = 1'b0;
    guard = 0;
    while (!done && guard < 400) begin
      rdy = stall ? guard[0] : 1'b1;
      l1Accept = (extra && guard == 1);
      outReady = rdy;
      if (outValid && rdy && gn < 80) begin
        got[gn] = outData;
        gn++;
        if (outLast) done = 1'b1;
      end
      @(negedge clk);
      guard++;
    end
    outReady = 1'b0;
    l1Accept = 1'b0;
    chk(done, req, "packet completed", 32'(done), 32'd1);
    chk(gn == n + 2, req, "packet length", 32'(gn), 32'(n + 2));
    if (gn >= 2) begin
      chk(got[0] == {4'hA, 4'h0, 8'(n), tg}, req, "header (R5)", 32'(got[0]),
          32'({4'hA, 4'h0, 8'(n), tg}));
      bodyOk = 1'b1;
      badAct = '0;
      badExp = '0;
      for (int i = 0; i < n && i + 1 < gn; i++) begin
        if (bodyOk && got[i + 1] != expW[i]) begin
          bodyOk = 1'b0;
          badAct = got[i + 1];
          badExp = expW[i];
        end
      end
      chk(bodyOk, req, "hit words in order (R3)", 32'(badAct), 32'(badExp));
      chk(got[gn - 1] == {4'hC, 10'd0, mLate, mOver, tg}, req, "trailer (R6)",
          32'(got[gn - 1]), 32'({4'hC, 10'd0, mLate, mOver, tg}));
    end
    mLate = 1'b0;
    mOver = 1'b0;
    nHits = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nh;
    for (int i = 0; i < 64; i++) begin
      mValid[i] = 1'b0;
      mWord[i]  = '0;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid in reset", 32'(outValid), 32'd0);
    chk(bcoCount == 8'd0, "R1", "bcoCount in reset", 32'(bcoCount), 32'd0);
    chk(chipTick == 1'b0, "R1", "chipTick in reset", 32'(chipTick), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R1", "outValid after reset", 32'(outValid), 32'd0);

    // R2: counter and forwarded tick
    tickN(1);
    chk(bcoCount == 8'd1, "R2", "count after one tick", 32'(bcoCount), 32'd1);
    chk(chipTick == 1'b1, "R2", "tick forwarded", 32'(chipTick), 32'd1);
    @(negedge clk);
    chk(chipTick == 1'b0, "R2", "tick forwarded once", 32'(chipTick), 32'd0);
    tickN(39);
    chk(bcoCount == 8'd40, "R2", "count after 40 ticks", 32'(bcoCount), 32'd40);

    // R3 R4 R7 R12: preload, then walk the trigger table
    for (int i = 0; i < 8; i++) sendHit(HIT_TAB[i]);
    for (int r = 0; r < 7; r++) begin
      runTrigger(TRIG_TAB[r][23:16], TRIG_TAB[r][0], 1'b0, "R4", nh);
      chk(nh == int'(TRIG_TAB[r][15:8]), "R7", "table hit count",
          32'(nh), 32'(TRIG_TAB[r][15:8]));
    end

    // R11: a second accept during a stalled packet
    runTrigger(8'd10, 1'b1, 1'b1, "R11", nh);
    repeat (4) @(negedge clk);
    chk(outValid == 1'b0, "R11", "no second packet", 32'(outValid), 32'd0);

    // R8: a future tag and a too-old tag are dropped and flagged
    sendHit({9'd9, 3'd1, 4'd3, 8'd41});
    sendHit({9'd8, 3'd2, 4'd3, 8'd200});
    runTrigger(8'd7, 1'b0, 1'b0, "R8", nh);
    chk(nh == 0, "R8", "dropped hits not stored", 32'(nh), 32'd0);
    runTrigger(8'd7, 1'b0, 1'b0, "R8", nh);

    // R9: window edge at age 63 and 64
    tickN(45);
    runTrigger(8'd63, 1'b0, 1'b0, "R9", nh);
    chk(nh == 1, "R9", "age 63 still sent", 32'(nh), 32'd1);
    tickN(1);
    runTrigger(8'd64, 1'b0, 1'b0, "R9", nh);
    chk(nh == 0, "R9", "age 64 expired", 32'(nh), 32'd0);

    // R10: fill to wrap and overwrite two live words
    for (int i = 0; i < 58; i++) sendHit({9'(i + 100), 3'(i), 4'(i), 8'd86});
    runTrigger(8'd0, 1'b1, 1'b0, "R10", nh);
    chk(nh == 58, "R10", "wrapped tag count", 32'(nh), 32'd58);
    runTrigger(8'd56, 1'b0, 1'b0, "R10", nh);
    chk(nh == 2, "R10", "overwritten words gone", 32'(nh), 32'd2);

    if (!ended) begin
      ended = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule